// File: doc/BRIEF.md
# Serial Flash Status Register Write Controller

This block is the device-side control path of a serial NOR flash for everything that touches its status register over an SPI mode-0 link. It handles three commands. The first arms writes. The second writes the register. The third reads the register back as a stream. The block keeps the write-arm latch and the busy flag, and it runs a timed update after each accepted write. It also refuses writes while the device is hardware-protected, which happens when the register's lock bit is set and the protect pin is held low.

All pins are resynchronised into a fast system clock and their edges are detected there. A write takes effect only when select is released exactly on a frame boundary. Once a write starts, a parameterised down-counter keeps the busy flag set. While that flag is set, polling reads keep working, and every other command is dropped.

The register packs as bit 7 = lock (write-disable), bits 6:5 = constant 0, bits 4:2 = three protect-level bits, bit 1 = write-arm latch, bit 0 = busy. Command codes are 0x06 (arm), 0x01 (write register) and 0x05 (read register).

Top module: `sfsr_top`

## Requirements
- R1: After reset the register reads 0x00 and the output enable `so_oe` is low.
- R2: A frame of exactly 8 bits carrying 0x06 sets the write-arm latch, so bit 1 reads 1.
- R3: An accepted write (0x01 plus one data byte, MSB first) copies data bits 7, 4, 3 and 2 into the register. It leaves bits 1 and 0 free of the data, and bits 6 and 5 always read 0.
- R4: A write frame sent while the write-arm latch is 0 has no effect.
- R5: A write frame is executed only when select rises after exactly 16 bits. With 15 or 17 bits the register, the latch and the busy flag all stay unchanged.
- R6: An accepted write sets the busy bit (bit 0) from the release of select for WR_CYCLES system clocks, and the bit can be polled with 0x05 during that time.
- R7: When the timed update ends, both the busy bit and the write-arm latch read 0.
- R8: A write is not executed while the lock bit is 1 and `wp_n` is low. The latch stays set in that case. With `wp_n` high the same write is executed.
- R9: While busy, 0x06 and 0x01 frames are ignored. Data sent in such a frame never reaches the register.
- R10: Command 0x05 drives the register MSB first on `so`, changing on falling `sck`, and repeats it byte after byte. `so_oe` is high only during that read phase.
- R11: Frames with any other command code change nothing and leave `so_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the device |
| wp_n | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data out of the device |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The hardest condition to reach is a command arriving while the timed update is still running, because the update window has to be longer than a full SPI frame. The bench sets a long cycle parameter and issues an arm frame and a conflicting write immediately after an accepted write, then polls and waits for the final value. Hardware protection needs the lock bit written first and the pin dropped afterwards, so that sequence is run directed. A seeded random loop then mixes pin levels, frame lengths and arm frames.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam logic [7:0] OP_ARM   = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h05;

  // register image: lock, two zeros, protect level, arm latch, busy
  function automatic logic [7:0] sr_pack(input logic lock, input logic [2:0] lvl,
                                         input logic arm, input logic busy);
    return {lock, 2'b00, lvl, arm, busy};
  endfunction

  // writable fields picked from the incoming data byte: {lock, lvl}
  function automatic logic [3:0] sr_fields(input logic [7:0] d);
    return {d[7], d[4:2]};
  endfunction
endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= RST_VAL[i];
        q[i]    <= RST_VAL[i];
      end else begin
        meta[i] <= d_in[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/sfsr_frame.sv
module sfsr_frame
  import sfsr_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi,
  input  logic [7:0]    status_now,
  output logic [CW-1:0] bit_cnt,
  output logic [7:0]    opcode,
  output logic [7:0]    data_byte,
  output logic          so_q,
  output logic          rd_mode
);
  localparam logic [CW-1:0] CMAX = '1;
  logic [6:0] shreg;
  logic       op_valid;
  logic [2:0] tx_cnt;
  logic [7:0] snap;

  assign rd_mode = cs_act && op_valid && (opcode == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; bit_cnt <= '0; opcode <= '0; data_byte <= '0;
      op_valid <= 1'b0; tx_cnt <= '0; snap <= '0; so_q <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      op_valid <= 1'b0;
      tx_cnt   <= '0;
    end else begin
      if (sck_rise) begin
        shreg <= {shreg[5:0], mosi};
        if (bit_cnt != CMAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CW'(7)) begin
          opcode   <= {shreg, mosi};
          op_valid <= 1'b1;
        end
        if (bit_cnt == CW'(15)) data_byte <= {shreg, mosi};
      end
      if (sck_fall && rd_mode) begin
        if (tx_cnt == 3'd0) begin
          snap <= status_now;
          so_q <= status_now[7];
        end else begin
          so_q <= snap[3'd7 - tx_cnt];
        end
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfsr_regs.sv
module sfsr_regs
  import sfsr_pkg::*;
#(
  parameter int WR_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_ev,
  input  logic       write_ev,
  input  logic [3:0] new_fields,
  output logic       lock,
  output logic [2:0] lvl,
  output logic       arm,
  output logic       busy,
  output logic       busy_done
);
  localparam int TW = $clog2(WR_CYCLES + 1);
  logic [TW-1:0] tmr;

  assign busy      = (tmr != '0);
  assign busy_done = (tmr == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0; lvl <= '0; arm <= 1'b0; tmr <= '0;
    end else begin
      if (write_ev) begin
        {lock, lvl} <= new_fields;
        tmr <= TW'(WR_CYCLES);
      end else if (busy) begin
        tmr <= tmr - 1'b1;
      end
      if (busy_done)   arm <= 1'b0;
      else if (arm_ev) arm <= 1'b1;
    end
  end
endmodule

// File: rtl/sfsr_top.sv
module sfsr_top
  import sfsr_pkg::*;
#(
  parameter int WR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int CW = 5;

  logic cs_n_s, sck_s, mosi_s, wp_n_s;
  logic cs_n_d, sck_d;
  sfsr_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({cs_n, sck, mosi, wp_n}),
    .q({cs_n_s, sck_s, mosi_s, wp_n_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d <= 1'b1; sck_d <= 1'b0;
    end else begin
      cs_n_d <= cs_n_s; sck_d <= sck_s;
    end
  end

  // named internal events, also used by the checker
  logic cs_act, cs_rise, sck_rise, sck_fall;
  assign cs_act   = !cs_n_s;
  assign cs_rise  = cs_n_s && !cs_n_d;
  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;

  logic [CW-1:0] bit_cnt;
  logic [7:0]    opcode, data_byte, status_now;
  logic          so_q, rd_mode;
  logic          lock, arm, busy, busy_done;
  logic [2:0]    lvl;

  assign status_now = sr_pack(lock, lvl, arm, busy);

  logic hw_prot, arm_ev, write_ev;
  assign hw_prot  = lock && !wp_n_s;
  assign arm_ev   = cs_rise && (bit_cnt == CW'(8))  && (opcode == OP_ARM)   && !busy;
  assign write_ev = cs_rise && (bit_cnt == CW'(16)) && (opcode == OP_WRITE) &&
                    arm && !busy && !hw_prot;

  sfsr_frame #(.CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi(mosi_s), .status_now(status_now),
    .bit_cnt(bit_cnt), .opcode(opcode), .data_byte(data_byte),
    .so_q(so_q), .rd_mode(rd_mode)
  );

  sfsr_regs #(.WR_CYCLES(WR_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .arm_ev(arm_ev), .write_ev(write_ev),
    .new_fields(sr_fields(data_byte)), .lock(lock), .lvl(lvl),
    .arm(arm), .busy(busy), .busy_done(busy_done)
  );

  assign so_oe = rd_mode;
  assign so    = rd_mode ? so_q : 1'b0;
endmodule

// File: rtl/sfsr_checker.sv
module sfsr_checker (
  input logic clk,
  input logic rst_n,
  input logic write_ev,
  input logic arm_ev,
  input logic busy_done,
  input logic arm,
  input logic busy,
  input logic hw_prot,
  input logic so_oe,
  input logic cs_act
);
  p_arm_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    write_ev |-> arm);
  p_prot_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    write_ev |-> !hw_prot);
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    write_ev |=> busy);
  p_arm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |=> (!arm && !busy));
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!arm_ev && !write_ev));
  p_oe_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> cs_act);
endmodule

bind sfsr_top sfsr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .write_ev(write_ev), .arm_ev(arm_ev),
  .busy_done(busy_done), .arm(arm), .busy(busy), .hw_prot(hw_prot),
  .so_oe(so_oe), .cs_act(cs_act)
);

// File: tb/tb_sfsr_top.sv
module tb_sfsr_top;
  localparam int CLK_PERIOD = 10;
  localparam int WR_CYCLES  = 1000;
  localparam int HALF       = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfsr_top #(.WR_CYCLES(WR_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  // bench model
  logic m_lock = 0, m_arm = 0;
  logic [2:0] m_lvl = 0;

  function automatic logic [7:0] exp_reg(input logic lk, input logic [2:0] lv,
                                         input logic ar, input logic bz);
    logic [7:0] r;
    r = 8'h00;
    r[7] = lk; r[4] = lv[2]; r[3] = lv[1]; r[2] = lv[0]; r[1] = ar; r[0] = bz;
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] op, input logic [7:0] data, input int nbits);
    logic [23:0] w;
    w = {op, data, 8'h00};
    cs_n = 0; wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[23-i]; wait_clk(HALF);
      sck = 1; wait_clk(HALF);
      sck = 0;
    end
    wait_clk(HALF); cs_n = 1; wait_clk(2*HALF);
  endtask

  // read register: returns first and last byte of an nbytes stream
  task automatic rdsr(input int nbytes, output logic [7:0] first, output logic [7:0] last,
                      output logic oe_ok);
    logic [7:0] b;
    oe_ok = 1;
    cs_n = 0; wait_clk(HALF);
    for (int i = 0; i < 8; i++) begin
      mosi = sfsr_pkg::OP_READ[7-i]; wait_clk(HALF);
      sck = 1; wait_clk(HALF);
      sck = 0;
    end
    first = 0; last = 0;
    for (int k = 0; k < nbytes; k++) begin
      for (int i = 0; i < 8; i++) begin
        wait_clk(HALF);
        b[7-i] = so;
        if (so_oe !== 1'b1) oe_ok = 0;
        sck = 1; wait_clk(HALF);
        sck = 0;
      end
      if (k == 0) first = b;
      last = b;
    end
    wait_clk(HALF); cs_n = 1; wait_clk(2*HALF);
  endtask

  function automatic logic will_write(input logic arm, input logic lock, input logic wp,
                                      input int nbits);
    return (nbits == 16) && arm && !(lock && !wp);
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] f, l;
    logic ok;
    void'($urandom(32'h5A17));
    wait_clk(5); rst_n = 1; wait_clk(5);

    check("R1 oe after reset", {7'd0, so_oe}, 8'h00);
    rdsr(2, f, l, ok);
    check("R1 reset value", f, 8'h00);
    check("R10 oe during read", {7'd0, ok}, 8'h01);

    send(8'h01, 8'h9C, 16);                   // R4: no arm latch
    rdsr(1, f, l, ok); check("R4 write without arm", f, 8'h00);

    send(8'h06, 8'h00, 8);                    // R2
    rdsr(1, f, l, ok); check("R2 arm sets bit1", f, 8'h02);

    send(8'h01, 8'hFF, 15);                   // R5 short
    rdsr(1, f, l, ok); check("R5 15-bit frame", f, 8'h02);
    send(8'h01, 8'hFF, 17);                   // R5 long
    rdsr(1, f, l, ok); check("R5 17-bit frame", f, 8'h02);

    send(8'h01, 8'hFF, 16);                   // R3/R6
    rdsr(2, f, l, ok);
    check("R6 busy polled", f, 8'h9F);
    check("R3 bits 6:5 zero", f & 8'h60, 8'h00);
    check("R10 repeated byte", l, f);
    send(8'h06, 8'h00, 8);                    // R9 during busy
    send(8'h01, 8'h00, 16);
    wait_clk(WR_CYCLES + 50);
    rdsr(1, f, l, ok);
    check("R7 arm and busy cleared", f, 8'h9C);
    check("R9 busy write ignored", f & 8'h9C, 8'h9C);

    wp_n = 0;                                 // R8 protected
    send(8'h06, 8'h00, 8);
    send(8'h01, 8'h00, 16);
    rdsr(1, f, l, ok); check("R8 protected write blocked", f, 8'h9E);
    wp_n = 1;
    send(8'h01, 8'h00, 16);
    wait_clk(WR_CYCLES + 50);
    rdsr(1, f, l, ok); check("R8 unprotected write done", f, 8'h00);

    send(8'hA5, 8'hFF, 16);                   // R11
    check("R11 oe low after other op", {7'd0, so_oe}, 8'h00);
    send(8'h04, 8'h00, 8);
    rdsr(1, f, l, ok); check("R11 other ops no effect", f, 8'h00);

    m_lock = 0; m_lvl = 0; m_arm = 0;
    for (int it = 0; it < 30; it++) begin
      logic [7:0] d;
      int nb, sel;
      logic wr;
      d = 8'($urandom);
      wp_n = 1'($urandom);
      if (($urandom % 10) < 7) begin send(8'h06, 8'h00, 8); m_arm = 1; end
      sel = $urandom % 6;
      nb = (sel == 0) ? 15 : (sel == 1) ? 17 : 16;
      if (sel == 5) begin
        send(8'hA5, d, 16); wr = 0;
      end else begin
        wr = will_write(m_arm, m_lock, wp_n, nb);
        send(8'h01, d, nb);
      end
      if (wr) begin
        m_lock = d[7]; m_lvl = d[4:2]; m_arm = 0;
        wait_clk(WR_CYCLES + 50);
      end
      rdsr(1, f, l, ok);
      check("R3 R5 R8 random write", f, exp_reg(m_lock, m_lvl, m_arm, 1'b0));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule